// File: doc/BRIEF.md
# Second-Stage Guest Address Page Walker

This block turns a 34-bit guest-physical address into a 34-bit host physical address. It walks a two-level table of 32-bit entries of the kind a hypervisor uses for its second translation stage. The root table is four times the usual size: it holds 4096 entries in 16 KB and is indexed by twelve address bits. The second level keeps the ordinary ten-bit index. A caller hands over one request at a time, giving the address, an access kind and a make-executable-readable flag. The walker reads one or two entries over a plain request/response memory port. It then reports either a physical address with its read, write and execute rights, or a fault that names the access kind and the address that failed.

The wider root index only selects the entry. A leaf found at the root level still covers exactly 4 MB. The output address takes only the ten low index bits from the guest address. The two extra high index bits never reach the output.

Top module: `gpa_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle, and a request is taken on a cycle with `reqValid` and `reqReady` both high. From the next cycle `reqReady` stays low until the response has been given, so only one walk is in flight. `memReqValid` is never high while `reqReady` is high.
- R2: The first entry read is at address {`rootPpn`[21:2], `reqAddr`[33:22], 2'b00}. The two low bits of `rootPpn` are ignored, because the 16 KB root table is aligned.
- R3: When the root entry is a pointer, the second read is at {entry[31:10], `reqAddr`[21:12], 2'b00}.
- R4: Entry encoding: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 6 accessed, bit 7 dirty, bits 31:10 the 22-bit page number. A valid entry with read, write and execute all clear is a pointer.
- R5: A leaf at the root level gives `rspPaddr` = {entry[31:20], `reqAddr`[21:0]}, which is a 4 MB page. `reqAddr`[33:32] has no effect on the result.
- R6: A leaf at the second level gives `rspPaddr` = {entry[31:10], `reqAddr`[11:0]}.
- R7: An entry with valid clear, or with write set and read clear, faults at either level.
- R8: A root-level leaf whose entry[19:10] is not zero faults as a misaligned superpage.
- R9: A leaf with user clear faults. So does a leaf with accessed clear. A write (`reqType`=1) to a leaf with dirty clear faults, but a read (0) or fetch (2) of that leaf does not.
- R10: A pointer found at the second level faults.
- R11: On success, `rspRead` = read OR (execute AND `reqMxr`), `rspWrite` = write and `rspExec` = execute.
- R12: `rspValid` is a one-cycle pulse in the cycle after the accepted memory response, and the walker is ready again in the cycle after that. On a fault, `rspFault`=1, `rspFaultType` equals the request's `reqType`, `rspFaultAddr` equals `reqAddr`, and `rspPaddr` and all three rights are zero.
- R13: `memReqValid` stays high with a stable address until a cycle with `memRspValid` high. `memRspData` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootPpn | input | 22 | Page number of the root table |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, can take a request |
| reqAddr | input | 34 | Guest-physical address |
| reqType | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| reqMxr | input | 1 | Lets execute-only pages be read |
| memReqValid | output | 1 | Entry read pending |
| memReqAddr | output | 34 | Byte address of the entry |
| memRspValid | input | 1 | Entry data present |
| memRspData | input | 32 | Entry data |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Walk faulted |
| rspPaddr | output | 34 | Translated address |
| rspRead | output | 1 | Read allowed |
| rspWrite | output | 1 | Write allowed |
| rspExec | output | 1 | Execute allowed |
| rspFaultType | output | 2 | Access kind of the faulting request |
| rspFaultAddr | output | 34 | Address of the faulting request |

## Verification
The key case is a root-level superpage whose guest address has both extra index bits set. A walker that widened the superpage mask by those bits would put the wrong twelve high bits in the output. One that indexed with only ten bits would read the wrong root entry, and the recorded read address shows it. The 4 KB path is checked both for the second-level read address and for the output address. Each fault cause is set up on its own: invalid, write-without-read, misaligned superpage, user clear, accessed clear, write to a clean page, and a pointer at the last level. A read of a clean page confirms that the dirty check is limited to writes. Execute-only pages are read with the flag both clear and set.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int GPA_W     = 34;
  localparam int PTE_W     = 32;
  localparam int OFF_W     = 12;
  localparam int VPN0_W    = 10;
  localparam int VPN1_W    = 12;
  localparam int PPN_W     = 22;
  localparam int PTE_PPN_L = PTE_W - PPN_W;
  localparam int ROOT_XTRA = VPN1_W - VPN0_W;
  localparam int SUPER_W   = PPN_W - VPN0_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accType_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic savePtr;
    logic latchResult;
    logic atLeaf;
  } walkStrobes_t;

  // low byte of an entry, most significant field first
  typedef struct packed {
    logic dirty;
    logic accessed;
    logic global;
    logic user;
    logic exec;
    logic write;
    logic read;
    logic valid;
  } pteFlags_t;
endpackage

// File: rtl/gw_pte_check.sv
module gw_pte_check
  import gw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             lastLevel,
  input  logic             isWrite,
  output logic             isPtr,
  output logic             fault
);
  pteFlags_t          flags;
  logic [PPN_W-1:0]   ppn;
  logic               superMisaligned;
  logic               leafFault;
  logic               unusedPteBits;

  assign flags           = pte[7:0];
  assign ppn             = pte[PTE_W-1:PTE_PPN_L];
  assign unusedPteBits   = ^{pte[PTE_PPN_L-1:8], flags.global};
  assign isPtr           = flags.valid & ~flags.read & ~flags.write & ~flags.exec;
  assign superMisaligned = ~lastLevel & (|ppn[VPN0_W-1:0]);

  always_comb begin
    leafFault = superMisaligned | ~flags.user | ~flags.accessed
              | (isWrite & ~flags.dirty);
    fault = ~flags.valid | (flags.write & ~flags.read);
    if (isPtr) fault = fault | lastLevel;
    else       fault = fault | leafFault;
  end
endmodule

// File: rtl/gw_ctrl.sv
module gw_ctrl
  import gw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  logic         pteIsPtr,
  input  logic         pteFault,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         rspValid,
  output walkStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_LEAF, ST_DONE} walkState_t;
  walkState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    strobes     = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.capture = 1'b1;
          stateNxt        = ST_ROOT;
        end
      end
      ST_ROOT: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          if (pteIsPtr && !pteFault) begin
            strobes.savePtr = 1'b1;
            stateNxt        = ST_LEAF;
          end else begin
            strobes.latchResult = 1'b1;
            stateNxt            = ST_DONE;
          end
        end
      end
      ST_LEAF: begin
        memReqValid    = 1'b1;
        strobes.atLeaf = 1'b1;
        if (memRspValid) begin
          strobes.latchResult = 1'b1;
          stateNxt            = ST_DONE;
        end
      end
      ST_DONE: begin
        rspValid = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/gw_datapath.sv
module gw_datapath
  import gw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strobes,
  input  logic [PPN_W-1:0]   rootPpn,
  input  logic [GPA_W-1:0]   reqAddr,
  input  logic [1:0]         reqType,
  input  logic               reqMxr,
  input  logic [PTE_W-1:0]   memRspData,
  output logic [GPA_W-1:0]   memReqAddr,
  output logic               pteIsPtr,
  output logic               pteFault,
  output logic               rspFault,
  output logic [GPA_W-1:0]   rspPaddr,
  output logic               rspRead,
  output logic               rspWrite,
  output logic               rspExec,
  output logic [1:0]         rspFaultType,
  output logic [GPA_W-1:0]   rspFaultAddr
);
  logic [GPA_W-1:0]  addrQ;
  accType_t          accQ;
  logic              mxrQ;
  logic [PPN_W-1:0]  tablePpnQ;
  logic [VPN1_W-1:0] vpnHi;
  logic [VPN0_W-1:0] vpnLo;
  logic [PPN_W-1:0]  ptePpn;
  pteFlags_t         pteFlags;
  logic [GPA_W-1:0]  leafAddr;
  logic              unusedRootLow;

  assign vpnHi         = addrQ[GPA_W-1 -: VPN1_W];
  assign vpnLo         = addrQ[OFF_W +: VPN0_W];
  assign ptePpn        = memRspData[PTE_W-1:PTE_PPN_L];
  assign pteFlags      = memRspData[7:0];
  assign unusedRootLow = ^rootPpn[ROOT_XTRA-1:0];

  // entry address: aligned root base with wide index, or pointer base with narrow index
  assign memReqAddr = strobes.atLeaf ? {tablePpnQ, vpnLo, 2'b00}
                                     : {rootPpn[PPN_W-1:ROOT_XTRA], vpnHi, 2'b00};

  gw_pte_check u_check (
    .pte      (memRspData),
    .lastLevel(strobes.atLeaf),
    .isWrite  (accQ == ACC_WRITE),
    .isPtr    (pteIsPtr),
    .fault    (pteFault)
  );

  // a superpage keeps its mask at the narrow index width
  always_comb begin
    if (strobes.atLeaf)
      leafAddr = {ptePpn, addrQ[OFF_W-1:0]};
    else
      leafAddr = {ptePpn[PPN_W-1 -: SUPER_W], addrQ[VPN0_W+OFF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      accQ      <= ACC_READ;
      mxrQ      <= 1'b0;
      tablePpnQ <= '0;
      rspFault  <= 1'b0;
      rspPaddr  <= '0;
      rspRead   <= 1'b0;
      rspWrite  <= 1'b0;
      rspExec   <= 1'b0;
    end else begin
      if (strobes.capture) begin
        addrQ <= reqAddr;
        accQ  <= accType_t'(reqType);
        mxrQ  <= reqMxr;
      end
      if (strobes.savePtr) tablePpnQ <= ptePpn;
      if (strobes.latchResult) begin
        rspFault <= pteFault;
        if (pteFault) begin
          rspPaddr <= '0;
          rspRead  <= 1'b0;
          rspWrite <= 1'b0;
          rspExec  <= 1'b0;
        end else begin
          rspPaddr <= leafAddr;
          rspRead  <= pteFlags.read | (pteFlags.exec & mxrQ);
          rspWrite <= pteFlags.write;
          rspExec  <= pteFlags.exec;
        end
      end
    end
  end

  assign rspFaultType = accQ;
  assign rspFaultAddr = addrQ;
endmodule

// File: rtl/gpa_walker.sv
module gpa_walker
  import gw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PPN_W-1:0]   rootPpn,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [GPA_W-1:0]   reqAddr,
  input  logic [1:0]         reqType,
  input  logic               reqMxr,
  output logic               memReqValid,
  output logic [GPA_W-1:0]   memReqAddr,
  input  logic               memRspValid,
  input  logic [PTE_W-1:0]   memRspData,
  output logic               rspValid,
  output logic               rspFault,
  output logic [GPA_W-1:0]   rspPaddr,
  output logic               rspRead,
  output logic               rspWrite,
  output logic               rspExec,
  output logic [1:0]         rspFaultType,
  output logic [GPA_W-1:0]   rspFaultAddr
);
  walkStrobes_t strobes;
  logic         pteIsPtr;
  logic         pteFault;

  gw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRspValid(memRspValid),
    .pteIsPtr   (pteIsPtr),
    .pteFault   (pteFault),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .rspValid   (rspValid),
    .strobes    (strobes)
  );

  gw_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rootPpn     (rootPpn),
    .reqAddr     (reqAddr),
    .reqType     (reqType),
    .reqMxr      (reqMxr),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .pteIsPtr    (pteIsPtr),
    .pteFault    (pteFault),
    .rspFault    (rspFault),
    .rspPaddr    (rspPaddr),
    .rspRead     (rspRead),
    .rspWrite    (rspWrite),
    .rspExec     (rspExec),
    .rspFaultType(rspFaultType),
    .rspFaultAddr(rspFaultAddr)
  );
endmodule

// File: rtl/gpa_walker_chk.sv
module gpa_walker_chk
  import gw_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [PPN_W-1:0] rootPpn,
  input logic             reqValid,
  input logic             reqReady,
  input logic [GPA_W-1:0] reqAddr,
  input logic             memReqValid,
  input logic [GPA_W-1:0] memReqAddr,
  input logic             memRspValid,
  input logic             rspValid,
  input logic             rspFault,
  input logic [GPA_W-1:0] rspPaddr,
  input logic [GPA_W-1:0] rspFaultAddr
);
  logic [GPA_W-1:0] lastAddr;

  always_ff @(posedge clk) begin
    if (!rstN)                      lastAddr <= '0;
    else if (reqValid && reqReady)  lastAddr <= reqAddr;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r1_no_mem_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);

  a_r2_root_addr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=>
      (memReqValid && memReqAddr == {$past(rootPpn[PPN_W-1:ROOT_XTRA]),
                                     $past(reqAddr[GPA_W-1 -: VPN1_W]), 2'b00}));

  a_r13_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> (memReqValid && $stable(memReqAddr)));

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  a_r12_after_mem: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memRspValid && memReqValid));

  a_r12_fault_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspFaultAddr == lastAddr && rspPaddr == '0));

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspPaddr[OFF_W-1:0] == lastAddr[OFF_W-1:0]);
endmodule

bind gpa_walker gpa_walker_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rootPpn     (rootPpn),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqAddr     (reqAddr),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .rspValid    (rspValid),
  .rspFault    (rspFault),
  .rspPaddr    (rspPaddr),
  .rspFaultAddr(rspFaultAddr)
);

// File: tb/sim_gpa_walker.sv
`timescale 1ns/1ps
module sim_gpa_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] rootPpn = 22'h000103;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [33:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        reqMxr = 1'b0;
  logic        memReqValid;
  logic [33:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid, rspFault, rspRead, rspWrite, rspExec;
  logic [33:0] rspPaddr, rspFaultAddr;
  logic [1:0]  rspFaultType;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic [31:0] memArr [logic [33:0]];
  logic [33:0] seenAddr [4];
  int nSeen = 0;

  localparam logic [33:0] ROOT_BASE = 34'h100000;

  always #2 clk = ~clk;

  gpa_walker u0 (
    .clk(clk), .rstN(rstN), .rootPpn(rootPpn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqType(reqType), .reqMxr(reqMxr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspFault(rspFault), .rspPaddr(rspPaddr),
    .rspRead(rspRead), .rspWrite(rspWrite), .rspExec(rspExec),
    .rspFaultType(rspFaultType), .rspFaultAddr(rspFaultAddr)
  );

  function automatic logic [31:0] rd(input logic [33:0] a);
    return memArr.exists(a) ? memArr[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkPte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  // memory model: answers two negedges after a read appears
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (memRspValid) begin
        memRspValid = 1'b0;
      end else if (memReqValid) begin
        if (lat == 1) begin
          memRspData = rd(memReqAddr);
          if (nSeen < 4) seenAddr[nSeen] = memReqAddr;
          nSeen++;
          memRspValid = 1'b1;
          lat = 0;
        end else lat++;
      end
    end
  end

  // behavioural reference walker
  task automatic refWalk(input logic [33:0] a, input logic [1:0] t, input logic m,
                         output bit f, output logic [33:0] pa, output bit r, w, x);
    logic [33:0] ea;
    logic [31:0] p;
    f = 0; pa = '0; r = 0; w = 0; x = 0;
    ea = ({12'h0, rootPpn} & ~34'h3) * 34'd4096 + {22'h0, a[33:22]} * 34'd4;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      p = rd(ea);
      if (!p[0] || (p[2] && !p[1])) begin f = 1; return; end
      if (!p[1] && !p[2] && !p[3]) begin
        if (lvl == 0) begin f = 1; return; end
        ea = {12'h0, p[31:10]} * 34'd4096 + {24'h0, a[21:12]} * 34'd4;
        continue;
      end
      if (lvl == 1 && p[19:10] != 0) begin f = 1; return; end
      if (!p[4] || !p[6] || (t == 2'd1 && !p[7])) begin f = 1; return; end
      if (lvl == 1) pa = ({12'h0, p[31:10]} << 12) | {12'h0, a[21:0]};
      else          pa = ({12'h0, p[31:10]} << 12) | {22'h0, a[11:0]};
      r = p[1] | (p[3] & m); w = p[2]; x = p[3];
      return;
    end
  endtask

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic runWalk(input logic [33:0] a, input logic [1:0] t, input logic m, input string tag);
    bit ef, er, ew, ex;
    logic [33:0] epa;
    int guard = 0;
    refWalk(a, t, m, ef, epa, er, ew, ex);
    nSeen = 0;
    @(negedge clk);
    chk(reqReady === 1'b1, {tag, " R1 ready before request"}, 64'(reqReady), 64'd1);
    reqAddr = a; reqType = t; reqMxr = m; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady === 1'b0, {tag, " R1 busy during walk"}, 64'(reqReady), 64'd0);
    while (rspValid !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    chk(rspFault === ef, {tag, " fault flag"}, 64'(rspFault), 64'(ef));
    chk(rspPaddr === epa, {tag, " paddr"}, 64'(rspPaddr), 64'(epa));
    chk({rspRead, rspWrite, rspExec} === {er, ew, ex}, {tag, " R11 rights"},
        64'({rspRead, rspWrite, rspExec}), 64'({er, ew, ex}));
    if (ef) begin
      chk(rspFaultType === t, {tag, " R12 fault type"}, 64'(rspFaultType), 64'(t));
      chk(rspFaultAddr === a, {tag, " R12 fault addr"}, 64'(rspFaultAddr), 64'(a));
    end
  endtask

  task automatic tSuperpage();
    logic [33:0] a = {2'b11, 10'h155, 10'h2AB, 12'h9C7};
    memArr.delete();
    memArr[ROOT_BASE + 34'(12'hD55) * 4] = mkPte({12'hABC, 10'h0}, 8'hDF);
    runWalk(a, 2'd0, 1'b0, "R5 superpage");
    chk(seenAddr[0] === 34'h103554, "R2 wide root index", 64'(seenAddr[0]), 64'h103554);
    chk(rspPaddr === {12'hABC, 10'h2AB, 12'h9C7}, "R5 4MB mask", 64'(rspPaddr),
        64'({12'hABC, 10'h2AB, 12'h9C7}));
    chk(rspFault === 1'b0, "R4 leaf flags", 64'(rspFault), 64'd0);
  endtask

  task automatic tFourK();
    logic [33:0] a = {12'h004, 10'h3F1, 12'h123};
    memArr.delete();
    memArr[34'h100010] = mkPte(22'h000200, 8'h01);
    memArr[34'h200FC4] = mkPte(22'h12345, 8'hD3);
    runWalk(a, 2'd0, 1'b0, "R6 4KB");
    chk(nSeen == 2 && seenAddr[1] === 34'h200FC4, "R3 leaf entry addr",
        64'(seenAddr[1]), 64'h200FC4);
    chk(rspPaddr === {22'h12345, 12'h123}, "R6 4KB paddr", 64'(rspPaddr),
        64'({22'h12345, 12'h123}));
  endtask

  task automatic tFaults();
    logic [33:0] a = {12'h010, 10'h001, 12'h0AA};
    logic [33:0] ra = ROOT_BASE + 34'h40;
    memArr.delete();
    runWalk(a, 2'd2, 1'b0, "R7 invalid");
    chk(rspFault === 1'b1 && rspFaultType === 2'd2, "R12 fetch fault", 64'(rspFaultType), 64'd2);
    memArr[ra] = mkPte({12'h111, 10'h0}, 8'hD5);
    runWalk(a, 2'd0, 1'b0, "R7 write-no-read");
    chk(rspFault === 1'b1, "R7 write-no-read", 64'(rspFault), 64'd1);
    memArr[ra] = mkPte(22'h000C01, 8'hDF);
    runWalk(a, 2'd0, 1'b0, "R8 misaligned");
    chk(rspFault === 1'b1, "R8 misaligned", 64'(rspFault), 64'd1);
    memArr[ra] = mkPte({12'h111, 10'h0}, 8'hCF);
    runWalk(a, 2'd0, 1'b0, "R9 user clear");
    chk(rspFault === 1'b1, "R9 user clear", 64'(rspFault), 64'd1);
    memArr[ra] = mkPte({12'h111, 10'h0}, 8'h9F);
    runWalk(a, 2'd0, 1'b0, "R9 accessed clear");
    chk(rspFault === 1'b1, "R9 accessed clear", 64'(rspFault), 64'd1);
    memArr[ra] = mkPte({12'h111, 10'h0}, 8'h57);
    runWalk(a, 2'd1, 1'b0, "R9 write clean");
    chk(rspFault === 1'b1 && rspFaultType === 2'd1, "R9 write clean", 64'(rspFault), 64'd1);
    runWalk(a, 2'd0, 1'b0, "R9 read clean");
    chk(rspFault === 1'b0, "R9 read clean", 64'(rspFault), 64'd0);
  endtask

  task automatic tPtrAtLeaf();
    logic [33:0] a = {12'h020, 10'h002, 12'h004};
    memArr.delete();
    memArr[ROOT_BASE + 34'h80] = mkPte(22'h000300, 8'h01);
    memArr[34'h300008] = mkPte(22'h000400, 8'h01);
    runWalk(a, 2'd0, 1'b0, "R10 pointer at leaf");
    chk(rspFault === 1'b1, "R10 pointer at leaf", 64'(rspFault), 64'd1);
  endtask

  task automatic tMxr();
    logic [33:0] a = {12'h030, 10'h3FF, 12'hFFF};
    memArr.delete();
    memArr[ROOT_BASE + 34'hC0] = mkPte({12'h222, 10'h0}, 8'hD9);
    runWalk(a, 2'd0, 1'b0, "R11 mxr off");
    chk(rspRead === 1'b0 && rspExec === 1'b1, "R11 exec-only no mxr", 64'(rspRead), 64'd0);
    runWalk(a, 2'd0, 1'b1, "R11 mxr on");
    chk(rspRead === 1'b1, "R11 exec-only with mxr", 64'(rspRead), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1 && memReqValid === 1'b0 && rspValid === 1'b0,
        "R1 reset state", 64'({reqReady, memReqValid, rspValid}), 64'b100);
    tSuperpage();
    tFourK();
    tFaults();
    tPtrAtLeaf();
    tMxr();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule